// File: doc/BRIEF.md
# Parallel-Input Serializing SPI Master

This block is a transmit-only serial master. It drives a serial clock, an active-low chip-select and a serial data line, and sends one downstream frame at a time. Each frame carries between 4 and 32 bits. The payload comes from one of two 32-bit words. The first is a host-written data word. The second is a snapshot of a 32-bit parallel input bus, taken at the moment the frame begins.

While the framing enable is held high, frames go out back to back. Two frames are always separated by a chip-select-high gap. The gap is set by a prescale code times a scale code, counted in peripheral clock cycles, and is then stretched up to the next serial clock period boundary. The serial clock runs in one of two modes. In continuous mode it toggles all the time. In gated mode it toggles only while chip-select is low. A two-entry register write port holds the configuration and the host data word. A busy level and a one-cycle end-of-frame pulse report progress.

Top module: `pser_spi_master`

## Requirements
- R1: After reset, and whenever busy is low, cs_n is 1 and sout is 0. The reset values are sck=0, cs_n=1, sout=0, busy=0, eof=0.
- R2: The frame length N comes from control bits [7:2]. A value below 4 is used as 4 and a value above 32 is used as 32. A frame sends bits N-1 down to 0 of the selected word, most significant bit first, one bit per SCK period.
- R3: Control bit 0 selects the payload source: 1 selects the host data word (write address 1), 0 selects the parallel inputs. The parallel inputs are sampled on the clock edge at which cs_n goes low.
- R4: Changes on par_in while a frame is being shifted have no effect on the bits of that frame.
- R5: The SCK period is 2*SCK_HALF clock cycles. SCK idles low and rises half way through each bit. sout changes only at the falling-edge boundary that starts a bit and stays steady for the whole bit.
- R6: When control bit 1 is 1, SCK toggles at all times, including the gap and idle. When it is 0, SCK is low whenever cs_n is high.
- R7: The gap between frames is the smallest whole number of SCK periods that is at least P*D clock cycles, and never less than one period. P comes from control bits [9:8] (codes 0,1,2,3 give 1,3,5,7). D comes from control bits [13:10] (code n gives 2^(n+1)).
- R8: While start_en is high, frames follow one another separated only by the gap. cs_n falls only at an SCK period boundary. If start_en is low when the gap ends, the block returns to idle.
- R9: busy is high from the first cycle cs_n is low until the gap ends. eof is a single-cycle pulse in the cycle in which cs_n rises at the end of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 host data word |
| cfg_wdata | input | 32 | Register write data |
| start_en | input | 1 | Enables back-to-back framing |
| par_in | input | 32 | Parallel input pins |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip-select |
| sout | output | 1 | Serial data out |
| busy | output | 1 | Frame or gap in progress |
| eof | output | 1 | End-of-frame pulse |

## Verification
The hardest case to reach from the ports is the gap rounding. It is only visible once a frame has ended while start_en is still high, and it needs P*D values that land below, on and above a multiple of the SCK period. The stimulus runs pairs of back-to-back frames under several prescale and scale codes, including one where P*D is an exact multiple and one where P*D is well above one period. It also changes par_in in the middle of a 32-bit frame, to show that the snapshot taken at chip-select assertion is what goes out. A behavioural model compares all five outputs against the design on every clock.

// File: rtl/pser_pkg.sv
package pser_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } pser_state_e;

  localparam int GAP_W    = 19;
  localparam int MIN_LEN  = 4;
  localparam int SRC_BIT  = 0;
  localparam int CONT_BIT = 1;
  localparam int LEN_LSB  = 2;

  function automatic logic [GAP_W-1:0] prescale_of(input logic [1:0] code);
    return GAP_W'({code, 1'b1});
  endfunction

  function automatic logic [GAP_W-1:0] scale_of(input logic [3:0] code);
    return GAP_W'(2) << code;
  endfunction

  function automatic logic [GAP_W-1:0] gap_cycles(input logic [1:0] pcode,
                                                  input logic [3:0] dcode);
    return prescale_of(pcode) * scale_of(dcode);
  endfunction

  function automatic int clamp_len(input int raw, input int max_len);
    if (raw < MIN_LEN) return MIN_LEN;
    if (raw > max_len) return max_len;
    return raw;
  endfunction

endpackage

// File: rtl/pser_baud.sv
module pser_baud #(
  parameter int SCK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic sck_int,
  output logic bnd
);
  localparam int PERIOD = 2 * SCK_HALF;
  localparam int PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= '0;
    else if (bnd) ph <= '0;
    else ph <= ph + 1'b1;
  end

  assign bnd     = (ph == PW'(PERIOD - 1));
  assign sck_int = (ph >= PW'(SCK_HALF));

  // R5: the internal clock stays low during the first half of every period
  a_r5_low_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> !sck_int);
endmodule

// File: rtl/pser_gap.sv
module pser_gap #(
  parameter int GW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [GW-1:0] load_val,
  output logic          expired
);
  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R7: once the count is spent it stays spent until reloaded
  a_r7_expired_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);
endmodule

// File: rtl/pser_shifter.sv
module pser_shifter #(
  parameter int DW = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          shift,
  input  logic          src_alt,
  input  logic [DW-1:0] alt_word,
  input  logic [DW-1:0] par_word,
  input  logic [LW-1:0] len,
  output logic          sout_bit,
  output logic          last_bit
);
  logic [DW-1:0] shreg;
  logic [LW-1:0] bits_left;
  logic [DW-1:0] src_word;

  assign src_word = src_alt ? alt_word : par_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      bits_left <= '0;
    end else if (load) begin
      shreg     <= src_word << (DW - int'(len));
      bits_left <= len;
    end else if (shift) begin
      shreg     <= shreg << 1;
      bits_left <= bits_left - 1'b1;
    end
  end

  assign sout_bit = shreg[DW-1];
  assign last_bit = (bits_left == LW'(1));

  // R2: a loaded frame never holds fewer than the minimum or more than DW bits
  a_r2_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bits_left >= LW'(pser_pkg::MIN_LEN) && bits_left <= LW'(DW)));
endmodule

// File: rtl/pser_spi_master.sv
module pser_spi_master #(
  parameter int SCK_HALF = 2,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          start_en,
  input  logic [DW-1:0] par_in,
  output logic          sck,
  output logic          cs_n,
  output logic          sout,
  output logic          busy,
  output logic          eof
);
  import pser_pkg::*;

  localparam int LW      = $clog2(DW + 1);
  localparam int PDT_LSB = LEN_LSB + LW;
  localparam int DT_LSB  = PDT_LSB + 2;
  localparam int PERIOD  = 2 * SCK_HALF;

  // configuration
  logic          src_alt_q, cont_q;
  logic [LW-1:0] len_raw_q;
  logic [1:0]    pdt_q;
  logic [3:0]    dt_q;
  logic [DW-1:0] alt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_alt_q <= 1'b0;
      cont_q    <= 1'b0;
      len_raw_q <= '0;
      pdt_q     <= '0;
      dt_q      <= '0;
      alt_q     <= '0;
    end else if (cfg_we) begin
      if (cfg_addr) alt_q <= cfg_wdata;
      else begin
        src_alt_q <= cfg_wdata[SRC_BIT];
        cont_q    <= cfg_wdata[CONT_BIT];
        len_raw_q <= cfg_wdata[LEN_LSB +: LW];
        pdt_q     <= cfg_wdata[PDT_LSB +: 2];
        dt_q      <= cfg_wdata[DT_LSB +: 4];
      end
    end
  end

  logic [LW-1:0] len_eff;
  assign len_eff = LW'(clamp_len(int'(len_raw_q), DW));

  // submodules
  logic sck_int, bnd;
  pser_baud #(.SCK_HALF(SCK_HALF)) u_baud (
    .clk(clk), .rst_n(rst_n), .sck_int(sck_int), .bnd(bnd)
  );

  pser_state_e st;
  logic start_go, frame_end, bit_adv, gap_to_idle, gap_expired, last_bit, sout_bit;
  logic [GAP_W-1:0] gap_load_val;

  assign gap_load_val = gap_cycles(pdt_q, dt_q) - 1'b1;

  pser_gap #(.GW(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(frame_end),
    .load_val(gap_load_val), .expired(gap_expired)
  );

  pser_shifter #(.DW(DW), .LW(LW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start_go), .shift(bit_adv),
    .src_alt(src_alt_q), .alt_word(alt_q), .par_word(par_in),
    .len(len_eff), .sout_bit(sout_bit), .last_bit(last_bit)
  );

  // named events
  always_comb begin
    start_go    = 1'b0;
    frame_end   = 1'b0;
    bit_adv     = 1'b0;
    gap_to_idle = 1'b0;
    unique case (st)
      ST_IDLE: start_go = start_en && bnd;
      ST_XFER: begin
        frame_end = bnd && last_bit;
        bit_adv   = bnd && !last_bit;
      end
      ST_GAP: begin
        start_go    = bnd && gap_expired && start_en;
        gap_to_idle = bnd && gap_expired && !start_en;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      eof <= 1'b0;
    end else begin
      eof <= frame_end;
      if (start_go) st <= ST_XFER;
      else if (frame_end) st <= ST_GAP;
      else if (gap_to_idle) st <= ST_IDLE;
    end
  end

  assign cs_n = (st != ST_XFER);
  assign sout = (st == ST_XFER) ? sout_bit : 1'b0;
  assign busy = (st != ST_IDLE);
  assign sck  = sck_int && (cont_q || st == ST_XFER);

  // checker state: cycles spent with cs_n high after a finished frame
  logic [31:0] gap_run;
  logic        seen_frame;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_run    <= '0;
      seen_frame <= 1'b0;
    end else begin
      gap_run <= cs_n ? gap_run + 1 : 32'd0;
      if (frame_end) seen_frame <= 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sout));
  a_r8_cs_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(bnd));
  a_r6_gated_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_q && cs_n) |-> !sck);
  a_r5_sout_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$past(bnd)) |-> $stable(sout));
  a_r9_eof_single: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof);
  a_r9_eof_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> $rose(cs_n));
  a_r7_gap_whole_periods: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && seen_frame) |->
      ((gap_run % PERIOD) == 0 && gap_run >= PERIOD));
endmodule

// File: tb/tb_pser_spi_master.sv
module tb_pser_spi_master;
  localparam int H  = 2;
  localparam int P2 = 2 * H;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_addr = 1'b0, start_en = 1'b0;
  logic [31:0] cfg_wdata = '0, par_in = '0;
  logic sck, cs_n, sout, busy, eof;

  int errors = 0, checks = 0, cycles = 0;

  pser_spi_master #(.SCK_HALF(H), .DW(32)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start_en(start_en), .par_in(par_in),
    .sck(sck), .cs_n(cs_n), .sout(sout), .busy(busy), .eof(eof)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ph, m_st, m_idx, m_len, m_gc;
  bit m_eof, m_src, m_cont;
  int m_lraw, m_pdt, m_dt;
  logic [31:0] m_word, m_alt;

  function automatic int exp_pd(input int pdt, input int dt);
    int p;
    case (pdt)
      0: p = 1; 1: p = 3; 2: p = 5; default: p = 7;
    endcase
    return p * (1 << (dt + 1));
  endfunction

  function automatic int exp_gap(input int pdt, input int dt);
    int k = 1;
    while (k * P2 < exp_pd(pdt, dt)) k++;
    return k * P2;
  endfunction

  function automatic int eff_len(input int raw);
    if (raw < 4) return 4;
    if (raw > 32) return 32;
    return raw;
  endfunction

  task automatic m_start();
    m_word = m_src ? m_alt : par_in;
    m_len  = eff_len(m_lraw);
    m_idx  = m_len - 1;
    m_st   = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_st = 0; m_idx = 0; m_gc = 0; m_eof = 0;
      m_src = 0; m_cont = 0; m_lraw = 0; m_pdt = 0; m_dt = 0;
      m_alt = '0; m_word = '0; m_len = 4;
    end else begin
      bit at_bnd;
      at_bnd = (m_ph == P2 - 1);
      m_eof = 0;
      if (m_st == 0) begin
        if (start_en && at_bnd) m_start();
      end else if (m_st == 1) begin
        if (at_bnd) begin
          if (m_idx == 0) begin m_st = 2; m_gc = 0; m_eof = 1; end
          else m_idx--;
        end
      end else begin
        if (at_bnd && (m_gc + 1 >= exp_pd(m_pdt, m_dt))) begin
          if (start_en) m_start(); else m_st = 0;
        end
        m_gc++;
      end
      m_ph = (m_ph + 1) % P2;
      if (cfg_we) begin
        if (cfg_addr) m_alt = cfg_wdata;
        else begin
          m_src  = cfg_wdata[0];
          m_cont = cfg_wdata[1];
          m_lraw = int'(cfg_wdata[7:2]);
          m_pdt  = int'(cfg_wdata[9:8]);
          m_dt   = int'(cfg_wdata[13:10]);
        end
      end
    end
  end

  // every-cycle comparison and port monitor
  logic [31:0] cap_word, last_word;
  int cap_nb, last_nb, frames, gap_cnt, last_gap, gap_tog, last_tog, eofs;
  logic prev_sck = 0, prev_cs = 1;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic e_sck, e_sout;
      e_sck  = (m_ph >= H) && (m_cont || m_st == 1);
      e_sout = (m_st == 1) ? m_word[m_idx] : 1'b0;
      chk(sck == e_sck, "R6", "sck", sck, e_sck);
      chk(cs_n == (m_st != 1), "R8", "cs_n", cs_n, m_st != 1);
      chk(sout == e_sout, "R2", "sout", sout, e_sout);
      chk(busy == (m_st != 0), "R9", "busy", busy, m_st != 0);
      chk(eof == m_eof, "R9", "eof", eof, m_eof);
      if (eof) eofs++;
      if (!cs_n && sck && !prev_sck) begin
        cap_word = {cap_word[30:0], sout}; cap_nb++;
      end
      if (cs_n) begin
        gap_cnt++;
        if (sck != prev_sck) gap_tog++;
      end
      if (cs_n && !prev_cs) begin
        last_word = cap_word; last_nb = cap_nb; frames++;
        cap_word = '0; cap_nb = 0; gap_cnt = 1; gap_tog = 0;
      end
      if (!cs_n && prev_cs) begin last_gap = gap_cnt; last_tog = gap_tog; end
      prev_sck = sck; prev_cs = cs_n;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ctrl(input bit src, input bit cont, input int len, input int pdt, input int dt);
    wr(1'b0, {18'd0, 4'(dt), 2'(pdt), 6'(len), cont, src});
  endtask

  task automatic run_frames(input int n);
    int target = frames + n;
    @(negedge clk);
    start_en = 1;
    while (frames < target) @(negedge clk);
    start_en = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic gap_case(input int pdt, input int dt);
    ctrl(1, 0, 8, pdt, dt);
    run_frames(2);
    chk(last_gap == exp_gap(pdt, dt), "R7", "gap cycles", last_gap, exp_gap(pdt, dt));
  endtask

  initial begin
    cap_word = '0; last_word = '0; cap_nb = 0; last_nb = 0; frames = 0;
    gap_cnt = 0; last_gap = 0; gap_tog = 0; last_tog = 0; eofs = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sck == 0 && cs_n == 1 && sout == 0 && busy == 0 && eof == 0,
        "R1", "reset outputs", {sck, cs_n, sout, busy, eof}, 5'b01000);
    rst_n = 1;
    repeat (6) @(negedge clk);
    chk(cs_n == 1 && busy == 0, "R1", "idle without start", {cs_n, busy}, 2'b10);

    // R3 host word, R2 length 8, MSB first
    wr(1'b1, 32'h1234_56A5);
    ctrl(1, 0, 8, 0, 0);
    run_frames(2);
    chk(last_word == 32'hA5, "R2", "8-bit host word", last_word, 32'hA5);
    chk(last_nb == 8, "R2", "bit count", last_nb, 8);
    chk(last_gap == exp_gap(0, 0), "R7", "minimum gap", last_gap, exp_gap(0, 0));
    chk(eofs == 2, "R9", "eof count", eofs, 2);
    chk(busy == 0, "R8", "return to idle", busy, 0);

    // R3 parallel source, R4 change mid-frame
    ctrl(0, 0, 32, 0, 0);
    par_in = 32'hDEAD_BEEF;
    @(negedge clk);
    start_en = 1;
    while (cs_n) @(negedge clk);
    start_en = 0;
    repeat (10) @(negedge clk);
    par_in = 32'h1234_5678;
    while (busy) @(negedge clk);
    chk(last_word == 32'hDEAD_BEEF, "R4", "snapshot kept", last_word, 32'hDEAD_BEEF);
    chk(last_nb == 32, "R3", "parallel 32-bit frame", last_nb, 32);

    // R2 clamping
    wr(1'b1, 32'hCAFE_F00D);
    ctrl(1, 0, 2, 0, 0);
    run_frames(1);
    chk(last_nb == 4 && last_word == 32'hD, "R2", "short clamp", last_word, 32'hD);
    ctrl(1, 0, 40, 0, 0);
    run_frames(1);
    chk(last_nb == 32 && last_word == 32'hCAFE_F00D, "R2", "long clamp", last_word, 32'hCAFE_F00D);

    // R7 gap rounding
    gap_case(1, 0);
    gap_case(3, 2);
    gap_case(2, 3);
    gap_case(3, 5);

    // R6 clock modes in the gap
    chk(last_tog == 0, "R6", "gated sck quiet in gap", last_tog, 0);
    ctrl(1, 1, 6, 1, 1);
    run_frames(2);
    chk(last_tog > 0, "R6", "continuous sck toggles in gap", last_tog, 1);
    chk(last_gap == exp_gap(1, 1), "R7", "gap continuous", last_gap, exp_gap(1, 1));
    chk(last_word == 32'h0D, "R5", "6-bit continuous frame", last_word, 32'h0D);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(negedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule